// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM array alive by issuing periodic CAS-before-RAS refresh cycles. A free-running interval timer, loaded from a period input, marks each refresh interval. Each time it expires, one refresh is owed, and the owed refreshes are held in a small saturating backlog counter. The memory's control strobes are shared with the normal access controller, so the block cannot take them whenever it likes. It raises a request while refreshes are owed, waits for the access controller's grant, and then drives the whole backlog as back-to-back strobe sequences. It holds a busy flag until the precharge gap after the last sequence has finished.

Each refresh sequence pulls CAS low first, then RAS after a programmable lead time. Both strobes stay low for a programmable hold time, then rise together, and a fixed precharge gap follows. No row address is needed because the DRAM supplies its own internal refresh row.

The block has two resets. Only the power-on reset clears it. The chip-level reset input is deliberately left out of the datapath, so that memory contents survive a system reset.

Top module: `dram_refresh_sched`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the block goes idle: `pend_cnt` = 0, `ref_req` = 0, `ref_busy` = 0, and `ras_n` = `cas_n` = 1 from that edge on. This also aborts a refresh sequence that is in progress.
- R2: With `refresh_en` = 1 and `period` = P ≥ 1, the owed count rises by one every P clocks. The first increment appears P rising edges after the enable is applied.
- R3: With `refresh_en` = 0 or `period` = 0, no refresh becomes owed. While no sequence is running and the block is disabled, the backlog is cleared at the next edge.
- R4: The owed count saturates at 7. Further interval expiries at 7 are lost.
- R5: In each refresh sequence, CAS is low alone for max(`cas_lead`,1) clocks. Then both strobes are low for max(`ras_hold`,1) clocks, and then both rise on the same edge. RAS is never low while CAS is high.
- R6: Every sequence ends with 2 clocks (parameter `PRE_CLKS`) in which both strobes are high and `ref_busy` is still 1, including after the last sequence.
- R7: `ref_req` equals (`pend_cnt` ≠ 0). No strobe moves until `ref_gnt` has been sampled high. `ref_busy` is high from the first CAS-low clock through the final precharge clock.
- R8: Once started, every owed refresh is issued back to back without a new grant, and `pend_cnt` decrements once per completed sequence.
- R9: Clearing `refresh_en` during a sequence does not cut that sequence short. When it completes, the remaining backlog is dropped and the bus is released.
- R10: `chip_rst_n` has no effect: interval timing and the backlog keep running while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| chip_rst_n | input | 1 | Chip-level reset; intentionally ignored by the refresh logic |
| refresh_en | input | 1 | Enables generation of new refresh requests |
| period | input | PERIOD_W | Refresh interval in clocks; zero disables |
| cas_lead | input | PHASE_W | Clocks CAS is low before RAS falls (0 means 1) |
| ras_hold | input | PHASE_W | Clocks both strobes stay low (0 means 1) |
| ref_gnt | input | 1 | Grant of the DRAM strobes from the access controller |
| ref_req | output | 1 | Refresh owed; asks for the strobes |
| ref_busy | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| pend_cnt | output | CNT_W | Number of refreshes owed |

## Verification
The embedded properties assume four things about the inputs:
- `period`, `cas_lead` and `ras_hold` do not change while a sequence is running or while an interval is being measured.
- The grant stays high for as long as `ref_busy` is high.
- `rst_n` is held low for several clocks at start-up.
- The interval-spacing property tolerates a change of period, but it is not checked against one.

The stimulus keeps within these assumptions. It reprograms the timing inputs only while the block is idle, or while it is stalled without a grant. It keeps the grant high across each whole drain window. During a drain it moves to a very long period, so that no interval expires before the backlog reaches zero.

// File: rtl/drf_pkg.sv
// Shared types for the DRAM refresh scheduler.
package drf_pkg;
    // Phase of the strobe sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAS  = 2'd1,
        PH_RAS  = 2'd2,
        PH_PRE  = 2'd3
    } ref_phase_e;
endpackage

// File: rtl/drf_interval_timer.sv
// Interval timer: counts system clocks and pulses `tick` once every `period`
// clocks while enabled. A period of zero counts as disabled.
// Assumes: period stays steady between reprogramming; a count that lands past
// a newly lowered period expires at once instead of wrapping.
module drf_interval_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick,
    output logic                active
);
    logic [PERIOD_W-1:0] cnt;

    // Enable qualification and expiry detection
    always_comb begin
        active = enable && (period != '0);
        tick   = active && (cnt >= period - PERIOD_W'(1));
    end

    // Count clocks, reload on expiry, park at zero while off
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + PERIOD_W'(1);
    end

    // Two expiries cannot be adjacent unless the interval is one clock
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > PERIOD_W'(1)) |=> (!tick || period != $past(period)));
endmodule

// File: rtl/drf_backlog_counter.sv
// Backlog counter: holds the number of owed refreshes, saturating at
// PEND_MAX. It is cleared when disabled once no sequence is running.
// Assumes: cyc_done pulses only while the count is nonzero.
module drf_backlog_counter #(
    parameter int PEND_MAX = 7,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             in_cycle,
    input  logic             cyc_done,
    output logic [CNT_W-1:0] pend
);
    logic full;

    // Saturation flag
    always_comb full = (pend == CNT_W'(PEND_MAX));

    // Add on expiry, subtract on completion, flush when disabled and idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (!active && (cyc_done || !in_cycle))
            pend <= '0;
        else if (tick && !cyc_done && !full)
            pend <= pend + CNT_W'(1);
        else if (!tick && cyc_done)
            pend <= pend - CNT_W'(1);
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && active && !cyc_done) |=> full);

    p_no_gain_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (pend <= $past(pend)));

    p_dec_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && active && !tick) |=> (pend == CNT_W'($past(pend) - CNT_W'(1))));
endmodule

// File: rtl/drf_cbr_sequencer.sv
// Strobe sequencer: after a grant, runs CAS-before-RAS sequences
// (CAS low, then RAS low, both high, precharge gap) back to back
// until the backlog is drained or refresh is disabled.
// Assumes: the grant stays high while busy; timing inputs are stable mid-sequence.
module drf_cbr_sequencer
    import drf_pkg::*;
#(
    parameter int PHASE_W  = 4,
    parameter int PRE_CLKS = 2,
    parameter int CNT_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               ref_gnt,
    input  logic [CNT_W-1:0]   pend,
    input  logic [PHASE_W-1:0] cas_lead,
    input  logic [PHASE_W-1:0] ras_hold,
    output logic               in_cycle,
    output logic               cyc_done,
    output logic               ref_busy,
    output logic               ras_n,
    output logic               cas_n
);
    localparam int PRE_W = $clog2(PRE_CLKS + 1);
    localparam int CW    = (PHASE_W > PRE_W) ? PHASE_W : PRE_W;

    ref_phase_e     phase;
    logic [CW-1:0]  ph_cnt;
    logic [CW-1:0]  lim;
    logic           ph_last;
    logic           more;
    logic           start;

    // Phase length selection; zero lengths stretch to one clock
    always_comb begin
        case (phase)
            PH_CAS:  lim = (cas_lead == '0) ? CW'(1) : CW'(cas_lead);
            PH_RAS:  lim = (ras_hold == '0) ? CW'(1) : CW'(ras_hold);
            default: lim = CW'(PRE_CLKS);
        endcase
        ph_last  = (ph_cnt >= lim - CW'(1));
        more     = active && (pend > CNT_W'(1));
        start    = (phase == PH_IDLE) && ref_gnt && (pend != '0) && active;
        cyc_done = (phase == PH_PRE) && ph_last;
        in_cycle = (phase != PH_IDLE);
    end

    // Phase register and in-phase clock counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            ph_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    ph_cnt <= '0;
                    if (start) phase <= PH_CAS;
                end
                PH_CAS: begin
                    if (ph_last) begin
                        phase  <= PH_RAS;
                        ph_cnt <= '0;
                    end else ph_cnt <= ph_cnt + CW'(1);
                end
                PH_RAS: begin
                    if (ph_last) begin
                        phase  <= PH_PRE;
                        ph_cnt <= '0;
                    end else ph_cnt <= ph_cnt + CW'(1);
                end
                default: begin
                    if (ph_last) begin
                        phase  <= more ? PH_CAS : PH_IDLE;
                        ph_cnt <= '0;
                    end else ph_cnt <= ph_cnt + CW'(1);
                end
            endcase
        end
    end

    // Strobe and busy decode from the phase
    always_comb begin
        cas_n    = !((phase == PH_CAS) || (phase == PH_RAS));
        ras_n    = !(phase == PH_RAS);
        ref_busy = in_cycle;
    end

    p_start_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy) |-> $past(ref_gnt));

    p_ras_after_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    p_release_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |=> (cas_n && ras_n && ref_busy));
endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh scheduler top: interval timer, saturating backlog and
// CAS-before-RAS sequencer. Only rst_n clears it; chip_rst_n is left
// out on purpose so refresh continues through a system reset.
module dram_refresh_sched #(
    parameter int  PERIOD_W = 16,
    parameter int  PHASE_W  = 4,
    parameter int  PRE_CLKS = 2,
    parameter int  PEND_MAX = 7,
    localparam int CNT_W    = $clog2(PEND_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chip_rst_n,
    input  logic                refresh_en,
    input  logic [PERIOD_W-1:0] period,
    input  logic [PHASE_W-1:0]  cas_lead,
    input  logic [PHASE_W-1:0]  ras_hold,
    input  logic                ref_gnt,
    output logic                ref_req,
    output logic                ref_busy,
    output logic                ras_n,
    output logic                cas_n,
    output logic [CNT_W-1:0]    pend_cnt
);
    logic tick;
    logic active;
    logic in_cycle;
    logic cyc_done;

    drf_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (refresh_en),
        .period (period),
        .tick   (tick),
        .active (active)
    );

    drf_backlog_counter #(.PEND_MAX(PEND_MAX), .CNT_W(CNT_W)) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .active   (active),
        .in_cycle (in_cycle),
        .cyc_done (cyc_done),
        .pend     (pend_cnt)
    );

    drf_cbr_sequencer #(.PHASE_W(PHASE_W), .PRE_CLKS(PRE_CLKS), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ref_gnt  (ref_gnt),
        .pend     (pend_cnt),
        .cas_lead (cas_lead),
        .ras_hold (ras_hold),
        .in_cycle (in_cycle),
        .cyc_done (cyc_done),
        .ref_busy (ref_busy),
        .ras_n    (ras_n),
        .cas_n    (cas_n)
    );

    // Request whenever a refresh is owed
    always_comb ref_req = (pend_cnt != '0);

    p_ext_rst_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !chip_rst_n) |=> (pend_cnt != '0));
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 4;
    // period, cas_lead, ras_hold
    localparam int TBL [NROWS][3] = '{'{1, 1, 1}, '{3, 2, 3}, '{5, 0, 2}, '{8, 3, 0}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_rst_n = 1'b1;
    logic        refresh_en = 1'b0;
    logic [15:0] period = '0;
    logic [3:0]  cas_lead = 4'd1;
    logic [3:0]  ras_hold = 4'd1;
    logic        ref_gnt = 1'b0;
    logic        ref_req, ref_busy, ras_n, cas_n;
    logic [2:0]  pend_cnt;

    int checks = 0;
    int failures = 0;

    dram_refresh_sched u0 (
        .clk(clk), .rst_n(rst_n), .chip_rst_n(chip_rst_n), .refresh_en(refresh_en),
        .period(period), .cas_lead(cas_lead), .ras_hold(ras_hold), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n),
        .pend_cnt(pend_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Observe strobes for n clocks, counting phase occupancy and edges
    task automatic run_window(input int n, output int c_only, output int both,
                              output int bad, output int pre_busy, output int busy_cyc,
                              output int cas_falls, output int ras_falls);
        logic pc, pr;
        c_only = 0; both = 0; bad = 0; pre_busy = 0; busy_cyc = 0;
        cas_falls = 0; ras_falls = 0;
        pc = cas_n; pr = ras_n;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!cas_n && ras_n) c_only++;
            if (!cas_n && !ras_n) both++;
            if (cas_n && !ras_n) bad++;
            if (cas_n && ras_n && ref_busy) pre_busy++;
            if (ref_busy) busy_cyc++;
            if (pc && !cas_n) cas_falls++;
            if (pr && !ras_n) ras_falls++;
            pc = cas_n; pr = ras_n;
        end
    endtask

    initial begin
        int c_only, both, bad, pre_busy, busy_cyc, cfall, rfall;
        wait_n(3);
        chk(int'(pend_cnt), 0, "R1 reset backlog");
        chk(int'(ref_req), 0, "R1 reset request");
        chk(int'(ref_busy), 0, "R1 reset busy");
        chk(int'(ras_n), 1, "R1 reset ras_n");
        chk(int'(cas_n), 1, "R1 reset cas_n");
        rst_n = 1'b1;

        // Vector table: interval timing, saturation and a full drain per row
        for (int i = 0; i < NROWS; i++) begin
            int p, ec, ew;
            p  = TBL[i][0];
            ec = (TBL[i][1] == 0) ? 1 : TBL[i][1];
            ew = (TBL[i][2] == 0) ? 1 : TBL[i][2];
            refresh_en = 1'b0; ref_gnt = 1'b0;
            wait_n(1);
            period = 16'(p); cas_lead = 4'(TBL[i][1]); ras_hold = 4'(TBL[i][2]);
            refresh_en = 1'b1;
            if (p > 1) begin
                wait_n(p - 1);
                chk(int'(pend_cnt), 0, "R2 before first expiry");
            end
            wait_n(1);
            chk(int'(pend_cnt), 1, "R2 first expiry");
            chk(int'(ref_req), 1, "R7 request follows backlog");
            wait_n(2 * p);
            chk(int'(pend_cnt), 3, "R2 third expiry");
            wait_n(6 * p);
            chk(int'(pend_cnt), 7, "R4 saturated at seven");
            chk(int'(cas_n), 1, "R7 no strobe without grant");
            chk(int'(ref_busy), 0, "R7 not busy without grant");
            period = 16'd1000;
            ref_gnt = 1'b1;
            run_window(7 * (ec + ew + 2) + 6, c_only, both, bad, pre_busy, busy_cyc, cfall, rfall);
            chk(cfall, 7, "R8 sequences issued");
            chk(c_only, 7 * ec, "R5 CAS lead clocks");
            chk(both, 7 * ew, "R5 RAS hold clocks");
            chk(bad, 0, "R5 RAS low with CAS high");
            chk(pre_busy, 7 * 2, "R6 precharge clocks");
            chk(busy_cyc, 7 * (ec + ew + 2), "R7 busy span");
            chk(int'(pend_cnt), 0, "R8 backlog drained");
            chk(int'(ref_busy), 0, "R7 bus released");
            chk(int'(ref_req), 0, "R7 request dropped");
        end

        // Disable while idle clears the backlog
        refresh_en = 1'b0; ref_gnt = 1'b0; wait_n(1);
        period = 16'd2; cas_lead = 4'd2; ras_hold = 4'd2; refresh_en = 1'b1;
        wait_n(20);
        chk(int'(pend_cnt), 7, "R4 saturated before idle disable");
        refresh_en = 1'b0;
        wait_n(1);
        chk(int'(pend_cnt), 0, "R3 idle disable flushes");

        // Disable during a sequence
        refresh_en = 1'b1;
        wait_n(20);
        ref_gnt = 1'b1;
        wait_n(1);
        chk(int'(cas_n), 0, "R9 sequence started");
        refresh_en = 1'b0;
        run_window(20, c_only, both, bad, pre_busy, busy_cyc, cfall, rfall);
        chk(rfall, 1, "R9 running sequence completes");
        chk(cfall, 0, "R9 no further sequence");
        chk(pre_busy, 2, "R6 precharge after aborted drain");
        chk(int'(pend_cnt), 0, "R9 backlog dropped");
        chk(int'(ref_busy), 0, "R9 bus released");
        ref_gnt = 1'b0;

        // Zero period acts as disable
        period = 16'd0; refresh_en = 1'b1;
        wait_n(40);
        chk(int'(pend_cnt), 0, "R3 zero period no requests");
        chk(int'(ref_req), 0, "R3 zero period no request line");

        // Chip reset does not stop refresh
        refresh_en = 1'b0; wait_n(1);
        period = 16'd4; chip_rst_n = 1'b0; refresh_en = 1'b1;
        wait_n(12);
        chk(int'(pend_cnt), 3, "R10 timing continues under chip reset");
        chip_rst_n = 1'b1;

        // Power-on reset in the middle of a sequence
        period = 16'd2;
        wait_n(20);
        ref_gnt = 1'b1;
        wait_n(2);
        chk(int'(cas_n), 0, "R1 sequence running before reset");
        rst_n = 1'b0;
        wait_n(1);
        chk(int'(cas_n), 1, "R1 reset aborts cas_n");
        chk(int'(ras_n), 1, "R1 reset aborts ras_n");
        chk(int'(pend_cnt), 0, "R1 reset clears backlog");
        chk(int'(ref_busy), 0, "R1 reset clears busy");
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule